// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Register Datapath

This block is a small register-transfer arithmetic unit. It holds two operand registers, an accumulator X and an operand Y, and feeds them into a single adder. Individual micro-command strobes decide what reaches the adder in a given cycle: X or zero on one side, and Y, the bitwise inverse of Y, or zero on the other. A separate strobe forces a carry-in of one. Addition is X plus Y. Subtraction is X plus inverted Y plus one. A write-back strobe captures the adder output into X at the clock edge. The strobes are expected to come from an external sequencer.

Inside the adder each operand is widened by one bit: its sign bit is copied into a second, upper sign position. The two sign bits of the sum tell the cases apart. 00 and 11 are valid results. 01 means the true result is above the largest positive value. 10 means it is below the most negative value. The upper sign bit is reported as the sign of the exact mathematical result. A second overflow indication is computed from the carries into and out of the sign position. Both flags are also collected into sticky status bits when a result is written back. The registers keep a single sign bit. The carry out of the widened adder is discarded.

Top module: `addsub_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, X, Y, `ovf_sticky` and `unf_sticky` are cleared to zero.
- R2: `ld_x` loads `x_din` into X and `ld_y` loads `y_din` into Y at the clock edge. If `ld_x` and `f_to_x` are both high, the external load wins.
- R3: The adder output `f_out` equals A + B + C modulo 2^W. A is X when `x_to_f` is high and 0 otherwise. B is Y for `y_to_f` alone, the bitwise inverse of Y for `ny_to_f` alone, and 0 when neither is high. C is 1 when `one_to_f` is high and 0 otherwise.
- R4: With `x_to_f`, `ny_to_f` and `one_to_f` high, `f_out` equals X − Y modulo 2^W.
- R5: `ovf` is high exactly when the signed value of A + B + C exceeds 2^(W−1) − 1. This is the double-sign pattern 01.
- R6: `unf` is high exactly when the signed value of A + B + C is below −2^(W−1). This is the double-sign pattern 10.
- R7: `true_sign` is 1 exactly when the signed value of A + B + C is negative, including when it is out of range.
- R8: `carry_ovf`, the mismatch between the carry into and the carry out of the sign position, always equals `ovf | unf`.
- R9: When `f_to_x` is high and `ld_x` is low, X takes the value of `f_out` at the clock edge. When both are low, X keeps its value. Y keeps its value whenever `ld_y` is low.
- R10: If `y_to_f` and `ny_to_f` are both high, B is 0 and `sel_err` is high. Otherwise `sel_err` is low.
- R11: On an edge with `f_to_x` high, `ovf_sticky` and `unf_sticky` are set if `ovf` or `unf` is high, respectively. Otherwise they hold their value. `clr_sticky` clears both at the edge and takes priority over setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_x | input | 1 | Load X from `x_din` |
| x_din | input | W | Parallel data for X |
| ld_y | input | 1 | Load Y from `y_din` |
| y_din | input | W | Parallel data for Y |
| x_to_f | input | 1 | Gate X to the adder |
| y_to_f | input | 1 | Gate Y to the adder |
| ny_to_f | input | 1 | Gate inverted Y to the adder |
| one_to_f | input | 1 | Carry-in of one |
| f_to_x | input | 1 | Write the adder result into X |
| clr_sticky | input | 1 | Clear the sticky status bits |
| f_out | output | W | Adder result, single sign bit |
| x_q | output | W | Contents of X |
| y_q | output | W | Contents of Y |
| ovf | output | 1 | Positive overflow (double sign 01) |
| unf | output | 1 | Negative underflow (double sign 10) |
| carry_ovf | output | 1 | Overflow from the sign-carry mismatch |
| true_sign | output | 1 | Upper sign bit, the sign of the exact result |
| sel_err | output | 1 | Y and inverted Y selected together |
| ovf_sticky | output | 1 | Latched positive overflow |
| unf_sticky | output | 1 | Latched negative underflow |

## Verification
The bench runs a 4-bit instance through every pair of X and Y in six strobe patterns: add, subtract, negate Y, increment X, add with inverted Y but no carry-in, and the illegal double Y selection. Each result is checked against integer arithmetic, so the edges of the range are always covered, for example −8 − 1, 7 + 1 and −8 − (−8).

Each kind of error shows up differently:
- A design that took the sign from the lower sign bit would report the wrong `true_sign` on every overflow.
- A design that swapped the 01 and 10 decodes would flip `ovf` and `unf`.
- A design that forgot the carry-in would be off by one on every subtraction.
- A design that let Y leak through on a conflicting selection would produce a nonzero B term.

Directed sequences cover the ordering corners: sticky bits accumulating across writes, a clear on the same edge as a new overflow, and an external load of X colliding with a write-back.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    // Pattern of the two sign positions of the widened sum.
    typedef enum logic [1:0] {
        DS_POS = 2'b00,
        DS_OVF = 2'b01,
        DS_UNF = 2'b10,
        DS_NEG = 2'b11
    } dsign_e;

endpackage

// File: rtl/addsub_opreg.sv
module addsub_opreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_ext,
    input  logic [W-1:0] din,
    input  logic         ld_res,
    input  logic [W-1:0] res,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (ld_ext) begin
            q <= din;
        end else if (ld_res) begin
            q <= res;
        end
    end

    // R9
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_ext && !ld_res) |=> $stable(q));

    // R2
    reg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ext |=> (q == $past(din)));

endmodule

// File: rtl/addsub_gate.sv
module addsub_gate #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         x_en,
    input  logic         y_en,
    input  logic         ny_en,
    input  logic         one_en,
    output logic [W:0]   a_ext,
    output logic [W:0]   b_ext,
    output logic         cin,
    output logic         err
);

    logic [W-1:0] y_sel;

    always_comb begin
        err = y_en && ny_en;
        unique case ({y_en, ny_en})
            2'b10:   y_sel = y;
            2'b01:   y_sel = ~y;
            default: y_sel = '0;
        endcase
        // Copy each single sign bit into both sign positions.
        a_ext = x_en ? {x[W-1], x} : '0;
        b_ext = {y_sel[W-1], y_sel};
        cin   = one_en;
    end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder #(
    parameter int W = 8
) (
    input  logic [W:0] a,
    input  logic [W:0] b,
    input  logic       cin,
    output logic [W:0] sum,
    output logic       carry_mis
);

    localparam int SB = W - 1;   // index of the single sign position

    logic [SB:0] low_sum;
    logic        c_into_sign;
    logic        c_from_sign;

    always_comb begin
        low_sum     = {1'b0, a[SB-1:0]} + {1'b0, b[SB-1:0]} + {{SB{1'b0}}, cin};
        c_into_sign = low_sum[SB];
        c_from_sign = (a[SB] & b[SB]) | (a[SB] & c_into_sign) | (b[SB] & c_into_sign);
        carry_mis   = c_into_sign ^ c_from_sign;
        // Carry out of the upper sign position is dropped (modulo arithmetic).
        sum         = a + b + {{W{1'b0}}, cin};
    end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
    import addsub_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_x,
    input  logic [WIDTH-1:0] x_din,
    input  logic             ld_y,
    input  logic [WIDTH-1:0] y_din,
    input  logic             x_to_f,
    input  logic             y_to_f,
    input  logic             ny_to_f,
    input  logic             one_to_f,
    input  logic             f_to_x,
    input  logic             clr_sticky,
    output logic [WIDTH-1:0] f_out,
    output logic [WIDTH-1:0] x_q,
    output logic [WIDTH-1:0] y_q,
    output logic             ovf,
    output logic             unf,
    output logic             carry_ovf,
    output logic             true_sign,
    output logic             sel_err,
    output logic             ovf_sticky,
    output logic             unf_sticky
);

    localparam int EW = WIDTH + 1;   // adder width with duplicated sign

    logic [EW-1:0] a_ext;
    logic [EW-1:0] b_ext;
    logic [EW-1:0] sum_ext;
    logic          cin;
    dsign_e        dsign;

    addsub_opreg #(.W(WIDTH)) i_xreg (
        .clk(clk), .rst_n(rst_n),
        .ld_ext(ld_x), .din(x_din),
        .ld_res(f_to_x), .res(f_out),
        .q(x_q)
    );

    addsub_opreg #(.W(WIDTH)) i_yreg (
        .clk(clk), .rst_n(rst_n),
        .ld_ext(ld_y), .din(y_din),
        .ld_res(1'b0), .res({WIDTH{1'b0}}),
        .q(y_q)
    );

    addsub_gate #(.W(WIDTH)) i_gate (
        .x(x_q), .y(y_q),
        .x_en(x_to_f), .y_en(y_to_f), .ny_en(ny_to_f), .one_en(one_to_f),
        .a_ext(a_ext), .b_ext(b_ext), .cin(cin), .err(sel_err)
    );

    addsub_adder #(.W(WIDTH)) i_adder (
        .a(a_ext), .b(b_ext), .cin(cin),
        .sum(sum_ext), .carry_mis(carry_ovf)
    );

    always_comb begin
        dsign     = dsign_e'(sum_ext[EW-1:EW-2]);
        f_out     = sum_ext[WIDTH-1:0];
        true_sign = sum_ext[EW-1];
        ovf       = (dsign == DS_OVF);
        unf       = (dsign == DS_UNF);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_sticky <= 1'b0;
            unf_sticky <= 1'b0;
        end else if (clr_sticky) begin
            ovf_sticky <= 1'b0;
            unf_sticky <= 1'b0;
        end else if (f_to_x) begin
            ovf_sticky <= ovf_sticky | ovf;
            unf_sticky <= unf_sticky | unf;
        end
    end

    // R8
    carry_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        carry_ovf == (ovf | unf));

    // R9
    writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_to_x && !ld_x) |=> (x_q == $past(f_out)));

    // R10
    sel_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_err && !x_to_f && !one_to_f) |-> (f_out == '0));

    // R11
    sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_to_x && !clr_sticky && (ovf || unf)) |=> (ovf_sticky || unf_sticky));

    // R11
    sticky_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_sticky |=> (!ovf_sticky && !unf_sticky));

endmodule

// File: tb/test_addsub_unit.sv
module test_addsub_unit;

    localparam int N    = 4;
    localparam int MOD  = 1 << N;
    localparam int MAXP = (1 << (N - 1)) - 1;
    localparam int MINN = -(1 << (N - 1));

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ld_x = 1'b0, ld_y = 1'b0;
    logic [N-1:0] x_din = '0, y_din = '0;
    logic         x_to_f = 1'b0, y_to_f = 1'b0, ny_to_f = 1'b0, one_to_f = 1'b0;
    logic         f_to_x = 1'b0, clr_sticky = 1'b0;
    logic [N-1:0] f_out, x_q, y_q;
    logic         ovf, unf, carry_ovf, true_sign, sel_err, ovf_sticky, unf_sticky;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    addsub_unit #(.WIDTH(N)) i_addsub_unit (
        .clk(clk), .rst_n(rst_n),
        .ld_x(ld_x), .x_din(x_din), .ld_y(ld_y), .y_din(y_din),
        .x_to_f(x_to_f), .y_to_f(y_to_f), .ny_to_f(ny_to_f),
        .one_to_f(one_to_f), .f_to_x(f_to_x), .clr_sticky(clr_sticky),
        .f_out(f_out), .x_q(x_q), .y_q(y_q),
        .ovf(ovf), .unf(unf), .carry_ovf(carry_ovf), .true_sign(true_sign),
        .sel_err(sel_err), .ovf_sticky(ovf_sticky), .unf_sticky(unf_sticky)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sval(input int u);
        return (u > MAXP) ? u - MOD : u;
    endfunction

    task automatic set_strobes(input bit xe, input bit ye, input bit nye, input bit one, input bit wb);
        x_to_f = xe; y_to_f = ye; ny_to_f = nye; one_to_f = one; f_to_x = wb;
    endtask

    task automatic load_xy(input int xv, input int yv);
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        ld_x = 1'b1; ld_y = 1'b1; x_din = N'(xv); y_din = N'(yv);
        clr_sticky = 1'b1;
        @(negedge clk);
        ld_x = 1'b0; ld_y = 1'b0; clr_sticky = 1'b0;
        #1;
        chk(x_q == N'(xv), "R2", int'(x_q), xv);
        chk(y_q == N'(yv), "R2", int'(y_q), yv);
    endtask

    // mode: 0 add, 1 sub, 2 negate Y, 3 increment X, 4 X plus inverted Y, 5 conflicting Y selection
    task automatic run_op(input int xv, input int yv, input int mode);
        int xs, ys, m, res;
        bit e_ovf, e_unf, e_err;
        load_xy(xv, yv);
        xs = sval(xv); ys = sval(yv); e_err = 1'b0;
        case (mode)
            0: begin set_strobes(1, 1, 0, 0, 1); m = xs + ys; end
            1: begin set_strobes(1, 0, 1, 1, 1); m = xs - ys; end
            2: begin set_strobes(0, 0, 1, 1, 1); m = -ys; end
            3: begin set_strobes(1, 0, 0, 1, 1); m = xs + 1; end
            4: begin set_strobes(1, 0, 1, 0, 1); m = xs - ys - 1; end
            default: begin set_strobes(1, 1, 1, 1, 1); m = xs + 1; e_err = 1'b1; end
        endcase
        res   = ((m % MOD) + MOD) % MOD;
        e_ovf = (m > MAXP);
        e_unf = (m < MINN);
        #1;
        if (mode == 1) chk(f_out == N'(res), "R4", int'(f_out), res);
        else           chk(f_out == N'(res), "R3", int'(f_out), res);
        chk(ovf == e_ovf, "R5", int'(ovf), int'(e_ovf));
        chk(unf == e_unf, "R6", int'(unf), int'(e_unf));
        chk(true_sign == (m < 0), "R7", int'(true_sign), int'(m < 0));
        chk(carry_ovf == (e_ovf | e_unf), "R8", int'(carry_ovf), int'(e_ovf | e_unf));
        chk(sel_err == e_err, "R10", int'(sel_err), int'(e_err));
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        #1;
        chk(x_q == N'(res), "R9", int'(x_q), res);
        chk(y_q == N'(yv), "R9", int'(y_q), yv);
        chk(ovf_sticky == e_ovf, "R11", int'(ovf_sticky), int'(e_ovf));
        chk(unf_sticky == e_unf, "R11", int'(unf_sticky), int'(e_unf));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        // R1: reset state, after loading nonzero values under reset
        ld_x = 1'b1; ld_y = 1'b1; x_din = 4'h5; y_din = 4'h3;
        repeat (3) @(negedge clk);
        ld_x = 1'b0; ld_y = 1'b0;
        #1;
        chk(x_q == 0, "R1", int'(x_q), 0);
        chk(y_q == 0, "R1", int'(y_q), 0);
        chk(!ovf_sticky && !unf_sticky, "R1", int'({ovf_sticky, unf_sticky}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Exhaustive sweep over all operand pairs and strobe patterns
        for (int mode = 0; mode < 6; mode++)
            for (int xv = 0; xv < MOD; xv++)
                for (int yv = 0; yv < MOD; yv++)
                    run_op(xv, yv, mode);

        // R11: sticky accumulates, survives a later clean write, cleared with clear priority
        load_xy(7, 1);
        @(negedge clk);
        set_strobes(1, 1, 0, 0, 1);          // 7 + 1 -> overflow
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        ld_y = 1'b1; y_din = 4'h0;
        @(negedge clk);
        ld_y = 1'b0;
        set_strobes(1, 1, 0, 0, 1);          // -8 + 0, no overflow
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        #1;
        chk(ovf_sticky == 1'b1, "R11", int'(ovf_sticky), 1);
        ld_y = 1'b1; y_din = 4'h1;
        @(negedge clk);
        ld_y = 1'b0;
        set_strobes(1, 0, 1, 1, 1);          // -8 - 1 -> underflow
        #1;
        chk(unf == 1'b1, "R6", int'(unf), 1);
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        #1;
        chk(ovf_sticky && unf_sticky, "R11", int'({ovf_sticky, unf_sticky}), 3);
        load_xy(7, 7);                        // clear during load
        @(negedge clk);
        set_strobes(1, 1, 0, 0, 1);           // 7 + 7 overflow with clear on same edge
        clr_sticky = 1'b1;
        @(negedge clk);
        set_strobes(0, 0, 0, 0, 0);
        clr_sticky = 1'b0;
        #1;
        chk(!ovf_sticky && !unf_sticky, "R11", int'({ovf_sticky, unf_sticky}), 0);

        // R2: external load wins over write-back
        load_xy(2, 3);
        @(negedge clk);
        set_strobes(1, 1, 0, 0, 1);
        ld_x = 1'b1; x_din = 4'h9;
        @(negedge clk);
        ld_x = 1'b0;
        set_strobes(0, 0, 0, 0, 0);
        #1;
        chk(x_q == 4'h9, "R2", int'(x_q), 9);

        // R9: X holds without strobes
        repeat (3) @(negedge clk);
        #1;
        chk(x_q == 4'h9, "R9", int'(x_q), 9);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule